// File: doc/BRIEF.md
# Group Hash Destination Address Filter

This block sits on the receive path and decides, for each incoming frame, whether the frame's destination MAC address is one the station wants. The caller presents the 48-bit destination address with a one-cycle strobe. One clock later the block returns a registered verdict together with a one-cycle valid pulse.

Individually addressed destinations are compared exactly against the station address input. Group destinations, which include broadcast, are looked up in a 64-bit hash table. The hash index is simply the top six bits of the final address byte, so the all-ones broadcast address lands on index 63. Broadcast is therefore admitted only while that table bit is set; there is no separate broadcast compare.

Software maintains the table through a simple write port. It can write one 32-bit half directly, add a single address to the table, empty the table while keeping broadcast, or open the table to every group address.

Top module: `gaf_filter`

## Requirements
- R1: After reset the table's lower half is all zeros and its upper half holds only bit 31 (table bit 63). The result valid output is low.
- R2: Each lookup strobe produces exactly one result valid pulse in the following cycle, together with its verdict. No valid pulse appears without a strobe one cycle earlier.
- R3: The address is a 48-bit value whose first byte occupies bits 47:40 and whose last byte occupies bits 7:0. The address is a group address when bit 40 is 1. Its table index is bits 7:2. A group address is accepted exactly when the table bit at that index is 1.
- R4: A direct write with half-select 0 replaces table bits 31:0 with the write data. With half-select 1 it replaces table bits 63:32.
- R5: A clear sets table bits 31:0 to zero and bits 63:32 to 0x80000000, so broadcast remains accepted.
- R6: An accept-all operation sets all 64 table bits to 1.
- R7: An add operation sets the table bit selected by bits 7:2 of the add address and leaves every other bit unchanged.
- R8: An individually addressed destination is accepted only when it equals the station address. The table has no effect on such a destination.
- R9: A lookup strobed in the same cycle as a table update uses the table as it stood before that update. The update applies from the next strobe on.
- R10: When several table operations are requested in one cycle, only the highest-priority one takes effect. The order, highest first, is clear, accept-all, direct write, add.
- R11: The broadcast address ff:ff:ff:ff:ff:ff is rejected whenever table bit 63 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_strb | input | 1 | Lookup strobe for the destination address |
| lk_addr | input | 48 | Destination address (first byte in bits 47:40) |
| sta_addr | input | 48 | Station's own individual address |
| tbl_clr | input | 1 | Clear table, keeping broadcast |
| tbl_all | input | 1 | Open table to every group address |
| wr_en | input | 1 | Direct write of one table half |
| wr_hi | input | 1 | Half select: 0 lower, 1 upper |
| wr_data | input | 32 | Direct write data |
| add_en | input | 1 | Add one address to the table |
| add_addr | input | 48 | Address to add |
| res_valid | output | 1 | Verdict valid pulse |
| res_accept | output | 1 | 1 = accept frame |

## Verification
A lookup and a table update can fall in the same cycle. The bench provokes this by strobing an address in the same cycle as a write, add or clear that flips that address's own table bit. The verdict must reflect the table as it stood before the update, and the next lookup of the same address must reflect the new value. Several table operations are also requested together in one cycle. Subsequent lookups must show that only the highest-priority operation landed.

// File: rtl/gaf_pkg.sv
package gaf_pkg;
    localparam int GAF_ADDR_W = 48;
    localparam int GAF_REG_W  = 32;
    localparam int GAF_IDX_W  = 6;

    typedef struct packed {
        logic [GAF_REG_W-1:0] hi;
        logic [GAF_REG_W-1:0] lo;
    } gaf_tbl_t;
endpackage

// File: rtl/gaf_index.sv
module gaf_index #(
    parameter int ADDR_W = gaf_pkg::GAF_ADDR_W,
    parameter int IDX_W  = gaf_pkg::GAF_IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              is_group
);
    // last byte sits in bits 7:0; index is its upper IDX_W bits
    localparam int LAST_MSB  = 7;
    localparam int GROUP_BIT = ADDR_W - 8;

    assign idx      = addr[LAST_MSB -: IDX_W];
    assign is_group = addr[GROUP_BIT];
endmodule

// File: rtl/gaf_table.sv
module gaf_table
    import gaf_pkg::*;
#(
    parameter int REG_W = GAF_REG_W,
    parameter int IDX_W = GAF_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             all,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wr_data,
    input  logic             add_en,
    input  logic [IDX_W-1:0] add_idx,
    output logic [2*REG_W-1:0] tbl
);
    localparam logic [REG_W-1:0] HI_KEEP_BCAST = {1'b1, {(REG_W-1){1'b0}}};

    typedef struct packed {
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [2*REG_W-1:0] flat;
        st_d = st_q;
        flat = {st_q.hi, st_q.lo};
        if (clr) begin
            st_d.lo = '0;
            st_d.hi = HI_KEEP_BCAST;
        end else if (all) begin
            st_d.lo = '1;
            st_d.hi = '1;
        end else if (wr_en) begin
            if (wr_hi) st_d.hi = wr_data;
            else       st_d.lo = wr_data;
        end else if (add_en) begin
            flat[add_idx] = 1'b1;
            st_d.hi = flat[2*REG_W-1:REG_W];
            st_d.lo = flat[REG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lo <= '0;
            st_q.hi <= HI_KEEP_BCAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl = {st_q.hi, st_q.lo};
endmodule

// File: rtl/gaf_decide.sv
module gaf_decide #(
    parameter int ADDR_W = gaf_pkg::GAF_ADDR_W,
    parameter int IDX_W  = gaf_pkg::GAF_IDX_W,
    parameter int TBL_W  = 2 * gaf_pkg::GAF_REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb,
    input  logic              is_group,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TBL_W-1:0]  tbl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] sta,
    output logic              res_valid,
    output logic              res_accept
);
    typedef struct packed {
        logic valid;
        logic accept;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d.valid  = strb;
        res_d.accept = 1'b0;
        if (strb) begin
            res_d.accept = is_group ? tbl[idx] : (addr == sta);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign res_accept = res_q.accept;
endmodule

// File: rtl/gaf_filter.sv
module gaf_filter
    import gaf_pkg::*;
#(
    parameter int ADDR_W = GAF_ADDR_W,
    parameter int REG_W  = GAF_REG_W,
    parameter int IDX_W  = GAF_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_strb,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [ADDR_W-1:0] sta_addr,
    input  logic              tbl_clr,
    input  logic              tbl_all,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              add_en,
    input  logic [ADDR_W-1:0] add_addr,
    output logic              res_valid,
    output logic              res_accept
);
    localparam int TBL_W = 2 * REG_W;

    logic [IDX_W-1:0] lk_idx, add_idx;
    logic             lk_group, add_group_unused;
    logic [TBL_W-1:0] tbl;

    gaf_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_idx (
        .addr(lk_addr), .idx(lk_idx), .is_group(lk_group)
    );

    gaf_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_add_idx (
        .addr(add_addr), .idx(add_idx), .is_group(add_group_unused)
    );

    gaf_table #(.REG_W(REG_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .clr(tbl_clr), .all(tbl_all),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .add_en(add_en), .add_idx(add_idx), .tbl(tbl)
    );

    gaf_decide #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TBL_W(TBL_W)) u_decide (
        .clk(clk), .rst_n(rst_n), .strb(lk_strb), .is_group(lk_group),
        .idx(lk_idx), .tbl(tbl), .addr(lk_addr), .sta(sta_addr),
        .res_valid(res_valid), .res_accept(res_accept)
    );
endmodule

// File: rtl/gaf_filter_chk.sv
module gaf_filter_chk #(
    parameter int ADDR_W = gaf_pkg::GAF_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_strb,
    input logic [ADDR_W-1:0] lk_addr,
    input logic [ADDR_W-1:0] sta_addr,
    input logic              tbl_clr,
    input logic              tbl_all,
    input logic              res_valid,
    input logic              res_accept
);
    localparam int GB = ADDR_W - 8;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_strb |=> res_valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_strb |=> !res_valid);

    a_r2_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> res_valid);

    a_r8_unicast_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_strb && !lk_addr[GB]) |=> (res_accept == $past(lk_addr == sta_addr)));

    a_r6_all_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_all && !tbl_clr) ##1 (lk_strb && lk_addr[GB]) |=> res_accept);

    a_r5_clear_keeps_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_clr ##1 (lk_strb && lk_addr[GB]) |=> (res_accept == $past(lk_addr[7:2] == 6'h3f)));
endmodule

bind gaf_filter gaf_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_strb(lk_strb), .lk_addr(lk_addr),
    .sta_addr(sta_addr), .tbl_clr(tbl_clr), .tbl_all(tbl_all),
    .res_valid(res_valid), .res_accept(res_accept)
);

// File: tb/gaf_filter_tb.sv
module gaf_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_strb = 1'b0;
    logic [47:0] lk_addr = '0;
    logic [47:0] sta_addr = 48'h02_11_22_33_44_55;
    logic        tbl_clr = 1'b0, tbl_all = 1'b0;
    logic        wr_en = 1'b0, wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic        add_en = 1'b0;
    logic [47:0] add_addr = '0;
    logic        res_valid, res_accept;

    gaf_filter u_dut (
        .clk(clk), .rst_n(rst_n), .lk_strb(lk_strb), .lk_addr(lk_addr),
        .sta_addr(sta_addr), .tbl_clr(tbl_clr), .tbl_all(tbl_all),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .add_en(add_en), .add_addr(add_addr),
        .res_valid(res_valid), .res_accept(res_accept)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [63:0] model = {32'h8000_0000, 32'h0};

    typedef struct {
        logic  acc;
        int    due;
        string tag;
    } exp_t;
    exp_t sb[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [47:0] grp(input logic [7:0] last);
        return {8'h01, 32'hA1B2_C3D4, last};
    endfunction

    // monitor: sample after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (!res_valid || res_accept !== e.acc) begin
                    fails++;
                    $display("FAIL %s: valid=%0b accept=%0b expected valid=1 accept=%0b",
                             e.tag, res_valid, res_accept, e.acc);
                end
            end else if (res_valid) begin
                checks++;
                fails++;
                $display("FAIL R2: valid=1 expected valid=0 at cycle %0d", cyc);
            end
        end
    end

    // drive current inputs for one cycle, push expectation, update model
    task automatic step(input string tag);
        if (lk_strb) begin
            exp_t e;
            e.acc = lk_addr[40] ? model[lk_addr[7:2]] : (lk_addr == sta_addr);
            e.due = cyc + 1;
            e.tag = tag;
            sb.push_back(e);
        end
        if (tbl_clr)      model = {32'h8000_0000, 32'h0};
        else if (tbl_all) model = '1;
        else if (wr_en) begin
            if (wr_hi) model[63:32] = wr_data;
            else       model[31:0]  = wr_data;
        end else if (add_en) model[add_addr[7:2]] = 1'b1;
        @(negedge clk);
        lk_strb = 0; tbl_clr = 0; tbl_all = 0; wr_en = 0; add_en = 0;
    endtask

    task automatic look(input logic [47:0] a, input string tag);
        lk_strb = 1; lk_addr = a;
        step(tag);
    endtask

    initial begin
        #200_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_accept !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid=%0b accept=%0b expected 0 0", res_valid, res_accept);
        end
        rst_n = 1;
        @(negedge clk);
        look(48'hFFFF_FFFF_FFFF, "R1 R11 bcast after reset");
        look(grp(8'h14), "R1 idx5 empty after reset");
        look(sta_addr, "R8 own address");
        look(48'h02_11_22_33_44_56, "R8 other unicast");
        wr_en = 1; wr_hi = 0; wr_data = 32'h0000_0020; step("R4 write lo");
        look(grp(8'h14), "R3 R4 idx5 set");
        look(grp(8'h17), "R3 idx5 low bits ignored");
        look(grp(8'h18), "R3 idx6 clear");
        wr_en = 1; wr_hi = 1; wr_data = 32'h0000_0004; step("R4 write hi");
        look(grp(8'h88), "R4 idx34 set");
        look(48'hFFFF_FFFF_FFFF, "R11 bcast bit63 off");
        add_en = 1; add_addr = grp(8'hC4); step("R7 add");
        look(grp(8'hC4), "R7 idx49 added");
        look(grp(8'h88), "R7 idx34 kept");
        look(grp(8'h14), "R7 idx5 kept");
        // lookup in same cycle as update
        wr_en = 1; wr_hi = 0; wr_data = 32'h0; lk_strb = 1; lk_addr = grp(8'h14);
        step("R9 old table on write");
        look(grp(8'h14), "R9 write now visible");
        add_en = 1; add_addr = grp(8'h30); lk_strb = 1; lk_addr = grp(8'h30);
        step("R9 old table on add");
        look(grp(8'h30), "R9 add now visible");
        tbl_all = 1; step("R6 all");
        look(grp(8'h5C), "R6 any group");
        look(48'hFFFF_FFFF_FFFF, "R6 bcast");
        look(48'h02_99_22_33_44_55, "R8 table ignored for unicast");
        look(sta_addr, "R8 own address with all");
        tbl_clr = 1; lk_strb = 1; lk_addr = grp(8'h5C); step("R9 old table on clear");
        look(grp(8'h5C), "R5 cleared");
        look(48'hFFFF_FFFF_FFFF, "R5 bcast kept");
        // priorities
        tbl_clr = 1; tbl_all = 1; step("R10 clr over all");
        look(grp(8'h00), "R10 clear won");
        tbl_all = 1; wr_en = 1; wr_hi = 1; wr_data = 32'h0; step("R10 all over write");
        look(grp(8'hFC), "R10 all won");
        tbl_clr = 1; step("clear");
        wr_en = 1; wr_hi = 0; wr_data = 32'h0000_0001; add_en = 1; add_addr = grp(8'h08);
        step("R10 write over add");
        look(grp(8'h00), "R10 write landed");
        look(grp(8'h08), "R10 add dropped");
        // back-to-back lookups
        for (int i = 0; i < 8; i++) look(grp(8'(i * 4)), "R2 back to back");
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL R2: %0d results missing, expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule